// File: doc/BRIEF.md
# Receive Byte Queue with Watermark Request

This block buffers bytes received from a serial bus byte engine until a host picks them up. The engine offers one byte per cycle on a push strobe. The host removes the oldest byte with a read strobe, and the byte is presented combinationally during that same cycle. The host also sees three things: an occupancy value that counts from zero, an 8-bit status byte carrying empty and full flags, and a level-sensitive request that goes to an interrupt block.

The host sets a watermark that counts from zero. The request is held high for as long as the queue holds at least watermark plus one bytes, so the host can ask to be woken after any number of bytes from 1 to 16. It does not have to wait for the storage to fill. A byte pushed while the queue is full and not being read is dropped, and a sticky overflow flag records the loss. A soft reset strobe empties the queue, restores the watermark to its maximum and clears the overflow flag.

Top module: `rx_byte_queue`

## Requirements
- R1: Bytes leave the queue in the order in which they were accepted, and up to 16 bytes can be held at once.
- R2: `occupancy` equals the number of stored bytes minus one, 4 bits wide, and reads 0 while the queue is empty.
- R3: `status` bit 6 is 1 exactly while the queue is empty, bit 5 is 1 exactly while it holds 16 bytes, and every other bit is 0.
- R4: While `pop_rd` is high and the queue is not empty, `rd_data` shows the oldest byte in that cycle, and that byte is removed at the next clock edge.
- R5: A read while the queue is empty returns `rd_data` = 0 and changes neither the contents nor the occupancy.
- R6: `rx_full_req` is 1 exactly while the stored count is greater than or equal to the watermark plus one.
- R7: The watermark is 4 bits wide. A write through `wm_wr` updates it at the clock edge, `wm_level` reads it back, and the new value governs `rx_full_req` from the following cycle.
- R8: A push while the queue holds 16 bytes and no read happens in the same cycle is dropped and sets `overflow`, which stays set until a reset.
- R9: A push and a read in the same cycle on a full queue both take effect, and the count stays at 16.
- R10: `soft_rst` empties the queue, sets the watermark to 15 and clears `overflow`, and it overrides any push, read or watermark write in the same cycle.
- R11: After `rst_n` is released the block is in the same state that a soft reset leaves: empty, watermark 15, no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush strobe |
| push_valid | input | 1 | Engine offers a received byte |
| push_data | input | 8 | Received byte |
| pop_rd | input | 1 | Host read strobe for the data register |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| wm_wr | input | 1 | Host write strobe for the watermark |
| wm_wdata | input | 4 | New watermark, counted from zero |
| wm_level | output | 4 | Current watermark |
| occupancy | output | 4 | Stored bytes minus one |
| status | output | 8 | Bit 6 empty, bit 5 full |
| rx_full_req | output | 1 | Level request: count at or above watermark plus one |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
A push from the engine and a read from the host can arrive in the same cycle. This matters most at the two edges of the queue: when it is full, the read makes room for the push, and when it is empty, the read sees nothing while the push still lands. Directed sequences fill the queue to 16 bytes and empty it before strobing both inputs together. Random phases then bias the traffic towards high push rates and high read rates so that the queue keeps hitting both edges. A bench model of the queue predicts the head byte, the occupancy, the flags and the request every cycle, and each prediction is compared with the ports.

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int EMPTY_BIT = 6,
  parameter int FULL_BIT  = 5,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_rd,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wm_wr,
  input  logic [PTR_W-1:0]  wm_wdata,
  output logic [PTR_W-1:0]  wm_level,
  output logic [PTR_W-1:0]  occupancy,
  output logic [7:0]        status,
  output logic              rx_full_req,
  output logic              overflow
);
  localparam int CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, wm;
  logic [CNT_W-1:0]  count;
  logic              ovf;
  logic              is_empty, is_full, do_pop, do_push, drop;

  assign is_empty = (count == '0);
  assign is_full  = (count == CNT_W'(DEPTH));
  assign do_pop   = pop_rd && !is_empty;
  assign do_push  = push_valid && (!is_full || do_pop);
  assign drop     = push_valid && !do_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      wm     <= PTR_W'(DEPTH - 1);
      ovf    <= 1'b0;
    end else if (soft_rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      wm     <= PTR_W'(DEPTH - 1);
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wm_wr) wm <= wm_wdata;
      if (drop)  ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!soft_rst && do_push) mem[wr_ptr] <= push_data;
  end

  assign rd_data     = is_empty ? '0 : mem[rd_ptr];
  assign occupancy   = is_empty ? '0 : PTR_W'(count - 1'b1);
  assign rx_full_req = (count >= (CNT_W'(wm) + CNT_W'(1)));
  assign wm_level    = wm;
  assign overflow    = ovf;

  always_comb begin
    status            = '0;
    status[EMPTY_BIT] = is_empty;
    status[FULL_BIT]  = is_full;
  end
endmodule

module rx_byte_queue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       push_valid,
  input logic       pop_rd,
  input logic       wm_wr,
  input logic [3:0] wm_wdata,
  input logic [7:0] rd_data,
  input logic [3:0] wm_level,
  input logic [3:0] occupancy,
  input logic [7:0] status,
  input logic       rx_full_req,
  input logic       overflow
);
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[5]));

  a_r2_empty_occ_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> occupancy == 4'd0);

  a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> rd_data == 8'd0);

  a_r5_empty_pop_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rd && status[6] && !push_valid && !soft_rst) |=> status[6]);

  a_r6_full_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> rx_full_req);

  a_r7_wm_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_wr && !soft_rst) |=> wm_level == $past(wm_wdata));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !soft_rst) |=> overflow);

  a_r10_soft_flush: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status[6] && wm_level == 4'd15 && !overflow && !rx_full_req));
endmodule

bind rx_byte_queue rx_byte_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .push_valid(push_valid),
  .pop_rd(pop_rd), .wm_wr(wm_wr), .wm_wdata(wm_wdata), .rd_data(rd_data),
  .wm_level(wm_level), .occupancy(occupancy), .status(status),
  .rx_full_req(rx_full_req), .overflow(overflow)
);

// File: tb/rx_byte_queue_bench.sv
module rx_byte_queue_bench;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       pop_rd = 1'b0;
  logic       wm_wr = 1'b0;
  logic [3:0] wm_wdata = '0;
  logic [7:0] rd_data;
  logic [3:0] wm_level, occupancy;
  logic [7:0] status;
  logic       rx_full_req, overflow;

  rx_byte_queue u_rx_byte_queue (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .push_valid(push_valid),
    .push_data(push_data), .pop_rd(pop_rd), .rd_data(rd_data), .wm_wr(wm_wr),
    .wm_wdata(wm_wdata), .wm_level(wm_level), .occupancy(occupancy),
    .status(status), .rx_full_req(rx_full_req), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;
  logic [7:0] mq[$];
  int  m_wm  = 15;
  bit  m_ovf = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_status(input int n);
    return (n == 0 ? 8'h40 : 0) | (n == DEPTH ? 8'h20 : 0);
  endfunction

  function automatic int exp_occ(input int n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  task automatic check_all();
    int n = mq.size();
    check("R2 occupancy", occupancy, exp_occ(n));
    check("R3 status", status, exp_status(n));
    check("R6 receive-full request", rx_full_req, (n >= m_wm + 1) ? 1 : 0);
    check("R7 watermark readback", wm_level, m_wm);
    check("R8 overflow flag", overflow, m_ovf);
  endtask

  task automatic model_reset();
    mq.delete();
    m_wm  = 15;
    m_ovf = 0;
  endtask

  task automatic cycle(input bit ps, input logic [7:0] pd, input bit pp,
                       input bit ww, input logic [3:0] wd, input bit sr);
    bit popping, accept;
    push_valid = ps; push_data = pd; pop_rd = pp;
    wm_wr = ww; wm_wdata = wd; soft_rst = sr;
    #1;
    if (pp && mq.size() > 0) check("R1 order R4 head byte", rd_data, mq[0]);
    if (pp && mq.size() == 0) check("R5 empty read data", rd_data, 0);
    @(posedge clk);
    if (sr) model_reset();
    else begin
      if (ww) m_wm = wd;
      popping = pp && (mq.size() > 0);
      accept  = ps && ((mq.size() < DEPTH) || popping);
      if (ps && !accept) m_ovf = 1;
      if (popping) void'(mq.pop_front());
      if (accept) mq.push_back(pd);
    end
    @(negedge clk);
    push_valid = 0; pop_rd = 0; wm_wr = 0; soft_rst = 0;
    check_all();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0071));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_reset();
    check_all();                                  // R11 reset state
    check("R11 reset empty", status, 8'h40);
    check("R11 reset watermark", wm_level, 15);

    // Fill to 16 with watermark 15: request only on the last byte (R6)
    for (int i = 0; i < DEPTH; i++) cycle(1, 8'(8'hA0 + i), 0, 0, 0, 0);
    check("R1 holds sixteen", occupancy, 15);
    check("R6 request at full", rx_full_req, 1);

    // Push while full without a read: dropped, overflow (R8)
    cycle(1, 8'hEE, 0, 0, 0, 0);
    check("R8 drop keeps count", occupancy, 15);
    check("R8 overflow set", overflow, 1);

    // Push and read together while full (R9)
    cycle(1, 8'h5A, 1, 0, 0, 0);
    check("R9 count held at sixteen", status, 8'h20);

    // Drain all, order checked inside cycle (R1, R4)
    for (int i = 0; i < DEPTH; i++) cycle(0, 0, 1, 0, 0, 0);
    check("R5 drained empty", status, 8'h40);

    // Read while empty (R5)
    cycle(0, 0, 1, 0, 0, 0);
    check("R5 empty read no move", occupancy, 0);

    // Push and read together on empty: push lands (R5)
    cycle(1, 8'h33, 1, 0, 0, 0);
    check("R5 push lands on empty read", occupancy, 0);
    check("R5 not empty", status, 8'h00);

    // Watermark 2: request after three bytes (R7)
    cycle(0, 0, 0, 1, 4'd2, 0);
    check("R7 watermark written", wm_level, 2);
    cycle(1, 8'h34, 0, 0, 0, 0);
    check("R7 two bytes no request", rx_full_req, 0);
    cycle(1, 8'h35, 0, 0, 0, 0);
    check("R7 three bytes request", rx_full_req, 1);
    cycle(0, 0, 1, 0, 0, 0);
    check("R6 drained below level", rx_full_req, 0);

    // Soft reset overrides push, read and watermark write (R10)
    cycle(1, 8'h77, 1, 1, 4'd3, 1);
    check("R10 soft flush empty", status, 8'h40);
    check("R10 watermark restored", wm_level, 15);
    check("R10 overflow cleared", overflow, 0);

    // Random phases biased to both edges
    for (int ph = 0; ph < 40; ph++) begin
      int pw = (ph % 2 == 0) ? 85 : 20;
      for (int k = 0; k < 60; k++) begin
        bit ps = ($urandom_range(99) < pw);
        bit pp = ($urandom_range(99) < 100 - pw);
        bit ww = ($urandom_range(99) < 4);
        bit sr = ($urandom_range(999) < 5);
        cycle(ps, 8'($urandom), pp, ww, 4'($urandom), sr);
      end
    end

    // Hard reset in the middle of traffic (R11)
    for (int i = 0; i < 5; i++) cycle(1, 8'(i), 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 4'd1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_reset();
    check_all();
    check("R11 hard reset empty", status, 8'h40);
    check("R11 hard reset watermark", wm_level, 15);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule